// File: doc/BRIEF.md
# Return Address Stack Predictor

This block predicts where a subroutine return will go. A return through a register can jump to a different place on each visit, because its target depends on which call site entered the subroutine. A prediction based only on the return's own address therefore tends to miss. The block keeps a small hardware stack of return addresses instead. When the fetch stage sees a call, it pulses `call_i` with the address of the instruction after the call, and the block pushes that address. When the fetch stage sees a return, it pulses `ret_i`. In the same cycle the block presents the most recent unreturned address as the predicted target, and it pops that entry at the clock edge.

The return address is known when the call is fetched, long before the matching return resolves. The stack has a fixed depth. Storage is a circular buffer with a top pointer and an occupancy count that saturates at the depth. When a call arrives on a full stack, the push still happens. The oldest entry is overwritten, so the newest return addresses are always kept. After such an overflow the stack can satisfy only as many returns as it holds. Any further return is reported as invalid.

Top module: `ras_predictor`

## Requirements
- R1: After reset the stack is empty: a return in the first cycle after reset gives `pred_valid_o` = 0.
- R2: When `ret_i` is 1 and the stack holds at least one entry, `pred_valid_o` is 1 in that same cycle and `pred_target_o` equals the top entry. The entry is removed at the next rising clock edge.
- R3: When `call_i` is 1 and `ret_i` is 0, `call_addr_i` is pushed at the rising clock edge. A return in the next cycle predicts that address.
- R4: Entries come back in last-in, first-out order across nested calls.
- R5: A push on a stack holding DEPTH entries discards the oldest entry and succeeds. After DEPTH+k pushes, DEPTH returns yield the newest DEPTH addresses, newest first. The next return gives `pred_valid_o` = 0.
- R6: A return on an empty stack gives `pred_valid_o` = 0 and changes no state. A later call followed by a return predicts that call's address.
- R7: When `call_i` and `ret_i` are both 1 and the stack is not empty, the prediction is the current top entry. The top entry is then replaced by `call_addr_i`, and the occupancy is unchanged.
- R8: When `call_i` and `ret_i` are both 1 and the stack is empty, `pred_valid_o` is 0 and `call_addr_i` is pushed as the only entry.
- R9: `pred_valid_o` is 0 in any cycle where `ret_i` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| call_i | input | 1 | A call was fetched this cycle |
| call_addr_i | input | ADDR_W | Address of the instruction following the call |
| ret_i | input | 1 | A return was fetched this cycle |
| pred_valid_o | output | 1 | The predicted target is meaningful this cycle |
| pred_target_o | output | ADDR_W | Predicted return target; undefined when `pred_valid_o` is 0 |

## Verification
The bench fills the stack past its depth and then drains it. A design that blocked the push when full, or that dropped the newest entry instead of the oldest, would return stale or missing addresses, or would report valid after the kept entries run out. Returns on an empty stack are followed by a call and a return. A design that moved its pointer on an empty pop would then predict the wrong slot. Calls and returns in the same cycle are tested on both an occupied stack and an empty one. A design that ordered them as push-then-pop, or that changed the depth, would show up as a wrong prediction or a wrong number of later valid returns.

// File: rtl/ras_pkg.sv
// Package: shared operation encoding for the return address stack.
// Assumes: consumers decode one operation per cycle.
package ras_pkg;
    typedef enum logic [1:0] {
        OP_IDLE = 2'b00,
        OP_POP  = 2'b01,
        OP_PUSH = 2'b10,
        OP_SWAP = 2'b11
    } ras_op_e;
endpackage

// File: rtl/ras_ctrl.sv
// Module: ras_ctrl
// Keeps the top pointer and the saturating occupancy of the circular stack,
// and issues the write strobe and write slot for the storage.
// Assumes: DEPTH >= 2; a pop is dropped when the stack is empty.
module ras_ctrl #(
    parameter int DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push_i,
    input  logic                         pop_i,
    output logic [$clog2(DEPTH)-1:0]     top_o,
    output logic                         empty_o,
    output logic                         wr_en_o,
    output logic [$clog2(DEPTH)-1:0]     wr_idx_o
);
    import ras_pkg::*;

    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [PW-1:0] LAST_IDX = PW'(DEPTH - 1);

    logic [PW-1:0] top_q, top_d, top_up, top_dn;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          is_empty, is_full;
    ras_op_e       op;

    // Neighbour slots in the circular buffer, wrapping at DEPTH.
    always_comb begin
        top_up = (top_q == LAST_IDX) ? '0 : top_q + PW'(1);
        top_dn = (top_q == '0) ? LAST_IDX : top_q - PW'(1);
    end

    assign is_empty = (cnt_q == '0);
    assign is_full  = (cnt_q == FULL_CNT);

    // Decode this cycle's operation; a pop on an empty stack is dropped.
    always_comb begin
        op = ras_op_e'({push_i, pop_i && !is_empty});
    end

    // Next pointer, next count and write request for the decoded operation.
    always_comb begin
        top_d    = top_q;
        cnt_d    = cnt_q;
        wr_en_o  = 1'b0;
        wr_idx_o = top_q;
        unique case (op)
            OP_PUSH: begin
                top_d    = top_up;
                cnt_d    = is_full ? cnt_q : cnt_q + CW'(1);
                wr_en_o  = 1'b1;
                wr_idx_o = top_up;
            end
            OP_POP: begin
                top_d = top_dn;
                cnt_d = cnt_q - CW'(1);
            end
            OP_SWAP: begin
                wr_en_o  = 1'b1;
                wr_idx_o = top_q;
            end
            default: ;
        endcase
    end

    // Pointer and count registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top_q <= '0;
            cnt_q <= '0;
        end else begin
            top_q <= top_d;
            cnt_q <= cnt_d;
        end
    end

    assign top_o   = top_q;
    assign empty_o = is_empty;

    assert_count_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= FULL_CNT);
    assert_full_push_saturates_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && is_full) |=> (cnt_q == FULL_CNT));
    assert_push_grows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && !is_full) |=> (cnt_q == $past(cnt_q) + CW'(1)));
    assert_empty_pop_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && is_empty) |=> (is_empty && $stable(top_q)));
    assert_swap_keeps_depth_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pop_i && !is_empty) |=> ($stable(cnt_q) && $stable(top_q)));
endmodule

// File: rtl/ras_store.sv
// Module: ras_store
// Holds the return addresses: one register per slot, one write port and
// one combinational read port.
// Assumes: the write and read indices are always below DEPTH.
module ras_store #(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 32
) (
    input  logic                      clk,
    input  logic                      wr_en_i,
    input  logic [$clog2(DEPTH)-1:0]  wr_idx_i,
    input  logic [ADDR_W-1:0]         wr_data_i,
    input  logic [$clog2(DEPTH)-1:0]  rd_idx_i,
    output logic [ADDR_W-1:0]         rd_data_o
);
    localparam int PW = $clog2(DEPTH);

    logic [ADDR_W-1:0] slot_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        // Capture the incoming address when this slot is selected.
        always_ff @(posedge clk) begin
            if (wr_en_i && (wr_idx_i == PW'(g)))
                slot_q[g] <= wr_data_i;
        end
    end

    // Present the addressed slot.
    assign rd_data_o = slot_q[rd_idx_i];
endmodule

// File: rtl/ras_predictor.sv
// Module: ras_predictor (top)
// Return-target predictor. A call pushes its return address, and a return
// pops the top entry and presents it as the prediction in the same cycle.
// Assumes: at most one call and one return per cycle; a simultaneous pair
// is a pop followed by a push.
module ras_predictor #(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              call_i,
    input  logic [ADDR_W-1:0] call_addr_i,
    input  logic              ret_i,
    output logic              pred_valid_o,
    output logic [ADDR_W-1:0] pred_target_o
);
    localparam int PW = $clog2(DEPTH);

    logic [PW-1:0] top_idx, wr_idx;
    logic          empty, wr_en;

    ras_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (call_i),
        .pop_i   (ret_i),
        .top_o   (top_idx),
        .empty_o (empty),
        .wr_en_o (wr_en),
        .wr_idx_o(wr_idx)
    );

    ras_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_store (
        .clk      (clk),
        .wr_en_i  (wr_en),
        .wr_idx_i (wr_idx),
        .wr_data_i(call_addr_i),
        .rd_idx_i (top_idx),
        .rd_data_o(pred_target_o)
    );

    // A prediction is offered only for a return that finds an entry.
    assign pred_valid_o = ret_i && !empty;

    assert_valid_needs_ret_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pred_valid_o |-> ret_i);
endmodule

// File: tb/ras_predictor_tb.sv
module ras_predictor_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 8;
    localparam int ADDR_W     = 32;
    localparam int WATCHDOG   = 20000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              call_i = 1'b0;
    logic [ADDR_W-1:0] call_addr_i = '0;
    logic              ret_i = 1'b0;
    logic              pred_valid_o;
    logic [ADDR_W-1:0] pred_target_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    ras_predictor #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .call_i(call_i), .call_addr_i(call_addr_i),
        .ret_i(ret_i), .pred_valid_o(pred_valid_o), .pred_target_o(pred_target_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // One cycle: drive at the falling edge, check just after, commit at the rising edge.
    task automatic step(input bit c, input logic [ADDR_W-1:0] a, input bit r,
                        input bit exp_v, input logic [ADDR_W-1:0] exp_t, input string req);
        @(negedge clk);
        call_i = c; call_addr_i = a; ret_i = r;
        #1;
        checks++;
        if (pred_valid_o !== exp_v || (exp_v && pred_target_o !== exp_t)) begin
            fails++;
            $display("FAIL %s: valid=%0b target=%h expected valid=%0b target=%h",
                     req, pred_valid_o, pred_target_o, exp_v, exp_t);
        end
        @(posedge clk);
    endtask

    task automatic idle();
        @(negedge clk);
        call_i = 1'b0; ret_i = 1'b0; call_addr_i = '0;
    endtask

    task automatic do_reset();
        idle();
        rst_n = 1'b0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // R1 and R9: empty after reset, no prediction without a return.
    task automatic t_reset();
        do_reset();
        step(0, '0, 1, 0, '0, "R1");
        step(1, 32'h1000, 0, 0, '0, "R9");
    endtask

    // R2, R3: a single call then a return.
    task automatic t_single();
        do_reset();
        step(1, 32'hA000_0004, 0, 0, '0, "R3");
        step(0, '0, 1, 1, 32'hA000_0004, "R2");
        step(0, '0, 1, 0, '0, "R2");
    endtask

    // R4: nested calls unwind newest first.
    task automatic t_nested();
        do_reset();
        step(1, 32'h0000_0100, 0, 0, '0, "R4");
        step(1, 32'h0000_0200, 0, 0, '0, "R4");
        step(1, 32'h0000_0300, 0, 0, '0, "R4");
        step(0, '0, 1, 1, 32'h0000_0300, "R4");
        step(0, '0, 1, 1, 32'h0000_0200, "R4");
        step(0, '0, 1, 1, 32'h0000_0100, "R4");
        step(0, '0, 1, 0, '0, "R4");
    endtask

    // R5: DEPTH+3 pushes keep the newest DEPTH, and the next return is invalid.
    task automatic t_overflow();
        do_reset();
        for (int i = 0; i < DEPTH + 3; i++)
            step(1, 32'h0001_0000 + 32'(i * 4), 0, 0, '0, "R5");
        for (int i = DEPTH + 2; i >= 3; i--)
            step(0, '0, 1, 1, 32'h0001_0000 + 32'(i * 4), "R5");
        step(0, '0, 1, 0, '0, "R5");
    endtask

    // R6: returns on empty leave the stack usable.
    task automatic t_empty_pop();
        do_reset();
        step(0, '0, 1, 0, '0, "R6");
        step(0, '0, 1, 0, '0, "R6");
        step(1, 32'h0BAD_0010, 0, 0, '0, "R6");
        step(1, 32'h0BAD_0020, 0, 0, '0, "R6");
        step(0, '0, 1, 1, 32'h0BAD_0020, "R6");
        step(0, '0, 1, 1, 32'h0BAD_0010, "R6");
        step(0, '0, 1, 0, '0, "R6");
    endtask

    // R7: call and return together on an occupied stack replace the top.
    task automatic t_swap();
        do_reset();
        step(1, 32'h0000_A000, 0, 0, '0, "R7");
        step(1, 32'h0000_B000, 0, 0, '0, "R7");
        step(1, 32'h0000_C000, 1, 1, 32'h0000_B000, "R7");
        step(0, '0, 1, 1, 32'h0000_C000, "R7");
        step(0, '0, 1, 1, 32'h0000_A000, "R7");
        step(0, '0, 1, 0, '0, "R7");
    endtask

    // R8: call and return together on an empty stack push one entry.
    task automatic t_swap_empty();
        do_reset();
        step(1, 32'h0000_D000, 1, 0, '0, "R8");
        step(0, '0, 1, 1, 32'h0000_D000, "R8");
        step(0, '0, 1, 0, '0, "R8");
    endtask

    initial begin
        t_reset();
        t_single();
        t_nested();
        t_overflow();
        t_empty_pop();
        t_swap();
        t_swap_empty();
        idle();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int n = 0; n < WATCHDOG; n++) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion within %0d cycles", WATCHDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule